// File: doc/BRIEF.md
# System Power State Controller

This block is the state machine that carries a platform between its working and sleeping conditions: full-on, the two processor idle states (C2 and C3), power-on suspend (S1), suspend to RAM (S3), suspend to disk (S4), soft off (S5) and mechanical off (G3). From the current state it drives three controls: the active-low main supply enable, the memory rail enable and the processor stop-clock request. It also presents the state as a 3-bit code.

Software puts the platform to sleep. It writes a sleep-type code and pulses a sleep-enable strobe at the same time. The block leaves a sleep state when the power button is pressed or when an enabled wake event arrives. It leaves an idle state on a return-from-idle request. The auxiliary-rail-good input has priority over every other input: when it drops, the block falls to mechanical off. When it comes back, a configuration bit chooses whether the block restores to full-on or to soft off.

All control pins are plain levels sampled on the rising clock edge. The block has no streaming interface, so there is no back-pressure.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), the state code is 7 (G3), `main_pwr_n` is 1, `mem_pwr_en` is 0 and `stop_clk_req` is 0.
- R2: If `aux_good` is low at a clock edge, the state becomes G3 (code 7) at that edge, whatever the state was before.
- R3: In G3 with `aux_good` high, the next state is full-on (code 0) when `aux_restore_on` is 1 and soft off (code 6) when it is 0.
- R4: In S4 (code 5) and S5 (code 6): `main_pwr_n` is 1, `mem_pwr_en` is 0 and `stop_clk_req` is 0.
- R5: In S3 (code 4): `main_pwr_n` is 1, `mem_pwr_en` is 1 and `stop_clk_req` is 0.
- R6: In full-on (code 0): `main_pwr_n` is 0, `mem_pwr_en` is 1 and `stop_clk_req` is 0. In C2 (1), C3 (2) and S1 (3), both rails stay on and `stop_clk_req` is 1.
- R7: A sleep state is entered only from full-on, and only at an edge where `slp_en` is 1. Sleep-type values 1 to 6 select the state with that code (1=C2, 2=C3, 3=S1, 4=S3, 5=S4, 6=S5). Values 0 and 7 leave the state at full-on. In every other state, `slp_en` has no effect.
- R8: In C2 or C3, `idle_exit` high moves the state to full-on. The power button and wake events do not change an idle state. `idle_exit` has no effect in the sleep states.
- R9: In S1, S3, S4 or S5, `pwr_button` high moves the state to full-on at the next edge.
- R10: In S1, S3, S4 or S5, a wake event bit `wake_evt[i]` moves the state to full-on only when `wake_en[i]` is also 1. An event whose enable bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aux_good | input | 1 | Auxiliary rail present |
| aux_restore_on | input | 1 | 1: restore to full-on after aux returns; 0: restore to soft off |
| pwr_button | input | 1 | Power button pressed (level) |
| slp_en | input | 1 | Sleep-enable strobe |
| slp_typ | input | 3 | Target sleep-type code |
| wake_evt | input | NUM_WAKE | Wake event lines |
| wake_en | input | NUM_WAKE | Per-event wake enables |
| idle_exit | input | 1 | Return-from-idle request |
| main_pwr_n | output | 1 | Main supply enable, active low |
| mem_pwr_en | output | 1 | Memory rail enable |
| stop_clk_req | output | 1 | Processor stop-clock request |
| state_code | output | 3 | Current state code |

## Verification
The assertions check on every cycle that losing the auxiliary rail lands in G3, that restoration follows `aux_restore_on`, that full-on holds when no sleep strobe arrives, and that the rail and stop-clock outputs match the current state. Some behaviour only the bench's scenarios can show. These are the full paths into and out of each state, that a wake event with its enable bit clear is ignored, that the sleep-type values 0 and 7 do nothing, and that a sleep strobe outside full-on is refused.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_FULL = 3'd0,
    PS_C2   = 3'd1,
    PS_C3   = 3'd2,
    PS_S1   = 3'd3,
    PS_S3   = 3'd4,
    PS_S4   = 3'd5,
    PS_S5   = 3'd6,
    PS_G3   = 3'd7
  } pwr_state_e;
endpackage

// File: rtl/sleep_decoder.sv
module sleep_decoder
  import pwr_state_pkg::*;
(
  input  logic [STATE_W-1:0] slp_typ,
  output logic               target_ok,
  output pwr_state_e         target
);
  always_comb begin
    target_ok = (slp_typ != PS_FULL) && (slp_typ != PS_G3);
    target    = pwr_state_e'(slp_typ);
  end
endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier #(
  parameter int NUM_WAKE = 7
) (
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_en,
  output logic                wake_any
);
  logic [NUM_WAKE-1:0] hit;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_gate
    assign hit[i] = wake_evt[i] & wake_en[i];
  end

  assign wake_any = |hit;
endmodule

// File: rtl/rail_decoder.sv
module rail_decoder
  import pwr_state_pkg::*;
(
  input  pwr_state_e state,
  output logic       main_pwr_n,
  output logic       mem_pwr_en,
  output logic       stop_clk_req
);
  always_comb begin
    main_pwr_n   = 1'b1;
    mem_pwr_en   = 1'b0;
    stop_clk_req = 1'b0;
    unique case (state)
      PS_FULL: begin
        main_pwr_n = 1'b0;
        mem_pwr_en = 1'b1;
      end
      PS_C2, PS_C3, PS_S1: begin
        main_pwr_n   = 1'b0;
        mem_pwr_en   = 1'b1;
        stop_clk_req = 1'b1;
      end
      PS_S3: mem_pwr_en = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int NUM_WAKE = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aux_good,
  input  logic                aux_restore_on,
  input  logic                pwr_button,
  input  logic                slp_en,
  input  logic [STATE_W-1:0]  slp_typ,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                idle_exit,
  output logic                main_pwr_n,
  output logic                mem_pwr_en,
  output logic                stop_clk_req,
  output logic [STATE_W-1:0]  state_code
);
  pwr_state_e state_q, state_d, sleep_target;
  logic       sleep_ok, wake_any;

  sleep_decoder u_sleep (
    .slp_typ   (slp_typ),
    .target_ok (sleep_ok),
    .target    (sleep_target)
  );

  wake_qualifier #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .wake_evt (wake_evt),
    .wake_en  (wake_en),
    .wake_any (wake_any)
  );

  rail_decoder u_rail (
    .state        (state_q),
    .main_pwr_n   (main_pwr_n),
    .mem_pwr_en   (mem_pwr_en),
    .stop_clk_req (stop_clk_req)
  );

  always_comb begin
    state_d = state_q;
    if (!aux_good) begin
      state_d = PS_G3;
    end else begin
      unique case (state_q)
        PS_G3:   state_d = aux_restore_on ? PS_FULL : PS_S5;
        PS_FULL: if (slp_en && sleep_ok) state_d = sleep_target;
        PS_C2, PS_C3: if (idle_exit) state_d = PS_FULL;
        default: if (pwr_button || wake_any) state_d = PS_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_G3;
    else        state_q <= state_d;
  end

  assign state_code = state_q;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
  import pwr_state_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               aux_good,
  input logic               aux_restore_on,
  input logic               slp_en,
  input logic [STATE_W-1:0] state_code,
  input logic               main_pwr_n,
  input logic               mem_pwr_en,
  input logic               stop_clk_req
);
  // R2
  aux_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_good |=> state_code == PS_G3);

  // R3
  aux_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == PS_G3 && aux_good) |=>
      state_code == ($past(aux_restore_on) ? PS_FULL : PS_S5));

  // R4
  soft_off_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == PS_S5 || state_code == PS_S4) |->
      (main_pwr_n && !mem_pwr_en && !stop_clk_req));

  // R5
  str_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == PS_S3 |-> (main_pwr_n && mem_pwr_en));

  // R6
  idle_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == PS_C2 || state_code == PS_C3 || state_code == PS_S1) |->
      (!main_pwr_n && mem_pwr_en && stop_clk_req));

  // R7
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == PS_FULL && aux_good && !slp_en) |=> state_code == PS_FULL);
endmodule

bind pwr_state_ctrl pwr_state_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .aux_good       (aux_good),
  .aux_restore_on (aux_restore_on),
  .slp_en         (slp_en),
  .state_code     (state_code),
  .main_pwr_n     (main_pwr_n),
  .mem_pwr_en     (mem_pwr_en),
  .stop_clk_req   (stop_clk_req)
);

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
  localparam int NW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          aux_good = 1'b0, aux_restore_on = 1'b0, pwr_button = 1'b0;
  logic          slp_en = 1'b0, idle_exit = 1'b0;
  logic [2:0]    slp_typ = '0;
  logic [NW-1:0] wake_evt = '0, wake_en = '0;
  logic          main_pwr_n, mem_pwr_en, stop_clk_req;
  logic [2:0]    state_code;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pwr_state_ctrl #(.NUM_WAKE(NW)) uut (
    .clk, .rst_n, .aux_good, .aux_restore_on, .pwr_button, .slp_en, .slp_typ,
    .wake_evt, .wake_en, .idle_exit, .main_pwr_n, .mem_pwr_en, .stop_clk_req,
    .state_code
  );

  typedef struct packed {
    logic       aux, ron, btn, sen;
    logic [2:0] typ;
    logic [6:0] evt, en;
    logic       idle;
    logic [2:0] st;
    logic       mn, mem, stp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,3'd0,7'h00,7'h00,1'b0,3'd7,1'b1,1'b0,1'b0,4'd2},  // R2 stay G3
    '{1'b1,1'b0,1'b0,1'b0,3'd0,7'h00,7'h00,1'b0,3'd6,1'b1,1'b0,1'b0,4'd3},  // R3 restore S5
    '{1'b1,1'b0,1'b0,1'b0,3'd0,7'h04,7'h00,1'b0,3'd6,1'b1,1'b0,1'b0,4'd10}, // R10 disabled
    '{1'b1,1'b0,1'b0,1'b0,3'd0,7'h04,7'h04,1'b0,3'd0,1'b0,1'b1,1'b0,4'd10}, // R10 enabled
    '{1'b1,1'b0,1'b0,1'b1,3'd0,7'h00,7'h00,1'b0,3'd0,1'b0,1'b1,1'b0,4'd7},  // R7 type 0
    '{1'b1,1'b0,1'b0,1'b1,3'd1,7'h00,7'h00,1'b0,3'd1,1'b0,1'b1,1'b1,4'd6},  // R6 C2
    '{1'b1,1'b0,1'b1,1'b0,3'd0,7'h7F,7'h7F,1'b0,3'd1,1'b0,1'b1,1'b1,4'd8},  // R8 btn/wake in C2
    '{1'b1,1'b0,1'b0,1'b0,3'd0,7'h00,7'h00,1'b1,3'd0,1'b0,1'b1,1'b0,4'd8},  // R8 idle exit
    '{1'b1,1'b0,1'b0,1'b1,3'd4,7'h00,7'h00,1'b0,3'd4,1'b1,1'b1,1'b0,4'd5},  // R5 S3
    '{1'b1,1'b0,1'b1,1'b0,3'd0,7'h00,7'h00,1'b0,3'd0,1'b0,1'b1,1'b0,4'd9},  // R9
    '{1'b1,1'b0,1'b0,1'b1,3'd5,7'h00,7'h00,1'b0,3'd5,1'b1,1'b0,1'b0,4'd4},  // R4 S4
    '{1'b1,1'b0,1'b0,1'b0,3'd0,7'h00,7'h00,1'b1,3'd5,1'b1,1'b0,1'b0,4'd8},  // R8 no idle exit in S4
    '{1'b1,1'b0,1'b1,1'b0,3'd0,7'h00,7'h00,1'b0,3'd0,1'b0,1'b1,1'b0,4'd9},  // R9
    '{1'b1,1'b0,1'b0,1'b1,3'd3,7'h00,7'h00,1'b0,3'd3,1'b0,1'b1,1'b1,4'd6},  // R6 S1
    '{1'b1,1'b0,1'b0,1'b0,3'd0,7'h7F,7'h7F,1'b0,3'd0,1'b0,1'b1,1'b0,4'd10}, // R10 from S1
    '{1'b1,1'b0,1'b0,1'b1,3'd2,7'h00,7'h00,1'b0,3'd2,1'b0,1'b1,1'b1,4'd6},  // R6 C3
    '{1'b0,1'b0,1'b0,1'b0,3'd0,7'h00,7'h00,1'b0,3'd7,1'b1,1'b0,1'b0,4'd2},  // R2 from C3
    '{1'b1,1'b1,1'b0,1'b0,3'd0,7'h00,7'h00,1'b0,3'd0,1'b0,1'b1,1'b0,4'd3},  // R3 restore FON
    '{1'b1,1'b0,1'b0,1'b1,3'd7,7'h00,7'h00,1'b0,3'd0,1'b0,1'b1,1'b0,4'd7},  // R7 type 7
    '{1'b1,1'b0,1'b0,1'b1,3'd6,7'h00,7'h00,1'b0,3'd6,1'b1,1'b0,1'b0,4'd4},  // R4 S5
    '{1'b1,1'b0,1'b0,1'b1,3'd1,7'h00,7'h00,1'b0,3'd6,1'b1,1'b0,1'b0,4'd7},  // R7 strobe outside FON
    '{1'b1,1'b0,1'b1,1'b0,3'd0,7'h00,7'h00,1'b0,3'd0,1'b0,1'b1,1'b0,4'd9},  // R9
    '{1'b1,1'b0,1'b0,1'b1,3'd4,7'h00,7'h00,1'b0,3'd4,1'b1,1'b1,1'b0,4'd5},  // R5
    '{1'b0,1'b0,1'b0,1'b0,3'd0,7'h00,7'h00,1'b0,3'd7,1'b1,1'b0,1'b0,4'd2}   // R2 from S3
  };

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {state,main_n,mem,stop} got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {state_code, main_pwr_n, mem_pwr_en, stop_clk_req};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", outs(), {3'd7, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      aux_good = VEC[i].aux; aux_restore_on = VEC[i].ron; pwr_button = VEC[i].btn;
      slp_en = VEC[i].sen; slp_typ = VEC[i].typ; wake_evt = VEC[i].evt;
      wake_en = VEC[i].en; idle_exit = VEC[i].idle;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VEC[i].rq, i), outs(),
            {VEC[i].st, VEC[i].mn, VEC[i].mem, VEC[i].stp});
    end

    // R1: reset while aux is good holds G3 and wins over restore
    aux_good = 1'b1; aux_restore_on = 1'b1; slp_en = 1'b0; pwr_button = 1'b0;
    @(negedge clk);
    check("R3 restore FON again", outs(), {3'd0, 1'b0, 1'b1, 1'b0});
    slp_en = 1'b1; slp_typ = 3'd4;
    @(negedge clk);
    slp_en = 1'b0;
    check("R5 S3 before reset", outs(), {3'd4, 1'b1, 1'b1, 1'b0});
    rst_n = 1'b0;
    #1;
    check("R1 async reset", outs(), {3'd7, 1'b1, 1'b0, 1'b0});
    repeat (2) @(negedge clk);
    check("R1 held reset", outs(), {3'd7, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after reset", outs(), {3'd0, 1'b0, 1'b1, 1'b0});

    // R10: every single enabled wake line wakes S5; mismatched lines do not
    for (int b = 0; b < NW; b++) begin
      slp_en = 1'b1; slp_typ = 3'd6;
      @(negedge clk);
      slp_en = 1'b0;
      wake_evt = NW'(1) << b; wake_en = ~(NW'(1) << b);
      @(negedge clk);
      check("R10 masked line", outs(), {3'd6, 1'b1, 1'b0, 1'b0});
      wake_en = NW'(1) << b;
      @(negedge clk);
      check("R10 enabled line", outs(), {3'd0, 1'b0, 1'b1, 1'b0});
      wake_evt = '0; wake_en = '0;
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule